// File: doc/BRIEF.md
# Accumulator and Register-File Operation Unit

This unit carries out four single-cycle data operations of a small 8-bit controller core. It holds an 8-bit accumulator, a 64-entry by 8-bit register file and two status flags, zero (Z) and carry (C). Each cycle the surrounding decode logic presents an operation code, a 6-bit register address, a destination-select bit, and the carry and half-carry produced by the preceding addition. The selected operation takes effect on the next rising clock edge.

The operations are: clearing the accumulator, clearing one register, bitwise inversion of one register (the result goes either back to the register or into the accumulator), and decimal correction of the accumulator after a binary add so that it holds packed BCD. Each operation follows its own rule for which flags it changes. A second, independent read port lets the rest of the core observe any register combinationally.

Top module: `acc_rf_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, the accumulator, Z, C and all 64 registers read 00h / 0.
- R2: Opcode 1 (accumulator clear) sets the accumulator to 00h and Z to 1. C and all registers are unchanged.
- R3: Opcode 2 (register clear) sets register `addr_i` to 00h and Z to 1. The accumulator, C and all other registers are unchanged.
- R4: Opcode 3 (invert) with `dest_i`=0 writes the bitwise inverse of register `addr_i` into the accumulator. The register keeps its value.
- R5: Opcode 3 with `dest_i`=1 writes the bitwise inverse back into register `addr_i`. The accumulator is unchanged.
- R6: Opcode 3 sets Z to 1 when the 8-bit result is 00h and clears it otherwise. C is unchanged.
- R7: Opcode 4 (decimal correction) adds 06h to the accumulator when its low nibble exceeds 9 or `hc_i` is 1. It adds 60h when the original high nibble exceeds 9 or `cy_i` is 1. The sum is taken modulo 256. C becomes 1 exactly when the 60h term is applied, and 0 otherwise. Z and the registers are unchanged.
- R8: Opcodes 0, 5, 6 and 7 change neither the accumulator, the flags nor any register.
- R9: Every operation completes in one cycle: its result is visible on the outputs right after the rising edge at which it was presented.
- R10: `rd_data_o` shows register `rd_addr_i` combinationally, with no added clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code: 0 none, 1 accumulator clear, 2 register clear, 3 invert, 4 decimal correction |
| addr_i | input | 6 | Register operand address |
| dest_i | input | 1 | Invert destination: 0 accumulator, 1 register |
| cy_i | input | 1 | Carry from the preceding addition |
| hc_i | input | 1 | Half-carry from the preceding addition |
| rd_addr_i | input | 6 | Observation read address |
| rd_data_o | output | 8 | Register contents at `rd_addr_i` |
| acc_o | output | 8 | Accumulator |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
The accumulator, Z and C change at the first rising edge after an operation is presented, and a register write is visible on the read port after that same edge. The bench drives every operation on a falling edge. It lets exactly one rising edge pass and compares all outputs on the following falling edge against a model it updates once per operation. Because the read port has no latency, the bench checks register contents within that same half cycle, both at the operand address and at a random second address.

// File: rtl/acu_pkg.sv
// Package: shared constants for the accumulator/register-file unit.
// Assumes an 8-bit data path split into two 4-bit nibbles for decimal work.
package acu_pkg;
    localparam int DW     = 8;
    localparam int OPW    = 3;
    localparam int NIBW   = DW / 2;

    localparam logic [OPW-1:0] OP_NONE = 3'd0;
    localparam logic [OPW-1:0] OP_CLRA = 3'd1;
    localparam logic [OPW-1:0] OP_CLRR = 3'd2;
    localparam logic [OPW-1:0] OP_INV  = 3'd3;
    localparam logic [OPW-1:0] OP_DADJ = 3'd4;

    // Register-file write request from the datapath
    typedef struct packed {
        logic          we;
        logic [DW-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/acu_regfile.sv
// Module: acu_regfile
// Flop-based register file: one synchronous write port, two combinational
// read ports (operand and observation). Assumes a synchronous active-low reset
// that clears every entry.
module acu_regfile #(
    parameter int AW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [AW-1:0]          wr_addr,
    input  acu_pkg::wr_req_t       wr_req,
    input  logic [AW-1:0]          rd0_addr,
    output logic [acu_pkg::DW-1:0] rd0_data,
    input  logic [AW-1:0]          rd1_addr,
    output logic [acu_pkg::DW-1:0] rd1_data
);
    localparam int DEPTH = 1 << AW;

    logic [acu_pkg::DW-1:0] mem [DEPTH];

    // One flop row per entry; each row clears on reset or takes its write
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[gi] <= '0;
            else if (wr_req.we && (wr_addr == AW'(gi)))
                mem[gi] <= wr_req.data;
        end
    end

    // Combinational read ports
    assign rd0_data = mem[rd0_addr];
    assign rd1_data = mem[rd1_addr];
endmodule

// File: rtl/acu_datapath.sv
// Module: acu_datapath
// Pure combinational next-state logic: decodes the operation code and works
// out the next accumulator, flag values and register write request.
// Assumes the caller registers the results; unknown codes hold all state.
module acu_datapath
    import acu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic           dest,
    input  logic           cy_in,
    input  logic           hc_in,
    input  logic [DW-1:0]  acc,
    input  logic [DW-1:0]  src,
    input  logic           z,
    input  logic           c,
    output logic [DW-1:0]  acc_nx,
    output logic           z_nx,
    output logic           c_nx,
    output wr_req_t        wr
);
    logic [DW-1:0] inv_val;
    logic          lo_fix;
    logic          hi_fix;
    logic [DW-1:0] dadj_val;

    // Inversion result and decimal-correction terms
    always_comb begin
        inv_val  = ~src;
        lo_fix   = (acc[NIBW-1:0] > NIBW'(9)) || hc_in;
        hi_fix   = (acc[DW-1:NIBW] > NIBW'(9)) || cy_in;
        dadj_val = acc + (lo_fix ? DW'(8'h06) : '0) + (hi_fix ? DW'(8'h60) : '0);
    end

    // Per-operation selection of next state and flag rules
    always_comb begin
        acc_nx  = acc;
        z_nx    = z;
        c_nx    = c;
        wr.we   = 1'b0;
        wr.data = '0;
        case (op)
            OP_CLRA: begin
                acc_nx = '0;
                z_nx   = 1'b1;
            end
            OP_CLRR: begin
                wr.we  = 1'b1;
                z_nx   = 1'b1;
            end
            OP_INV: begin
                z_nx = (inv_val == '0);
                if (dest) begin
                    wr.we   = 1'b1;
                    wr.data = inv_val;
                end else begin
                    acc_nx = inv_val;
                end
            end
            OP_DADJ: begin
                acc_nx = dadj_val;
                c_nx   = hi_fix;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_rf_unit.sv
// Module: acc_rf_unit (top)
// Holds the accumulator and the Z/C flags, and connects the register file to
// the next-state datapath. One operation per cycle; results land on the next
// rising edge. Synchronous active-low reset.
module acc_rf_unit #(
    parameter int AW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [acu_pkg::OPW-1:0] op_i,
    input  logic [AW-1:0]          addr_i,
    input  logic                   dest_i,
    input  logic                   cy_i,
    input  logic                   hc_i,
    input  logic [AW-1:0]          rd_addr_i,
    output logic [acu_pkg::DW-1:0] rd_data_o,
    output logic [acu_pkg::DW-1:0] acc_o,
    output logic                   z_o,
    output logic                   c_o
);
    logic [acu_pkg::DW-1:0] acc_q, acc_d;
    logic                   z_q, z_d, c_q, c_d;
    logic [acu_pkg::DW-1:0] src_data;
    acu_pkg::wr_req_t       wr_req;

    acu_regfile #(.AW(AW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_addr  (addr_i),
        .wr_req   (wr_req),
        .rd0_addr (addr_i),
        .rd0_data (src_data),
        .rd1_addr (rd_addr_i),
        .rd1_data (rd_data_o)
    );

    acu_datapath u_dp (
        .op     (op_i),
        .dest   (dest_i),
        .cy_in  (cy_i),
        .hc_in  (hc_i),
        .acc    (acc_q),
        .src    (src_data),
        .z      (z_q),
        .c      (c_q),
        .acc_nx (acc_d),
        .z_nx   (z_d),
        .c_nx   (c_d),
        .wr     (wr_req)
    );

    // Accumulator and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            z_q   <= 1'b0;
            c_q   <= 1'b0;
        end else begin
            acc_q <= acc_d;
            z_q   <= z_d;
            c_q   <= c_d;
        end
    end

    assign acc_o = acc_q;
    assign z_o   = z_q;
    assign c_o   = c_q;
endmodule

// File: rtl/acu_checker.sv
// Module: acu_checker
// Property checks on the unit's ports and operand read data, attached to
// every acc_rf_unit instance through bind.
module acu_checker #(
    parameter int AW = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [acu_pkg::OPW-1:0] op_i,
    input logic                    dest_i,
    input logic [acu_pkg::DW-1:0]  acc_o,
    input logic                    z_o,
    input logic                    c_o,
    input logic [acu_pkg::DW-1:0]  src_q
);
    import acu_pkg::*;

    a_r2_clra_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CLRA |=> (acc_o == '0) && z_o && (c_o == $past(c_o)));

    a_r3_clrr_z_set: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CLRR |=> z_o && (acc_o == $past(acc_o)) && (c_o == $past(c_o)));

    a_r4_inv_to_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INV) && !dest_i |=> acc_o == ~$past(src_q));

    a_r5_inv_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INV) && dest_i |=> acc_o == $past(acc_o));

    a_r6_inv_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_INV |=> (c_o == $past(c_o)) && (z_o == ($past(src_q) == 8'hFF)));

    a_r7_dadj_keeps_z: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_DADJ |=> z_o == $past(z_o));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NONE) || (op_i > OP_DADJ) |=> $stable(acc_o) && $stable(z_o) && $stable(c_o));
endmodule

bind acc_rf_unit acu_checker #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .dest_i (dest_i),
    .acc_o  (acc_o),
    .z_o    (z_o),
    .c_o    (c_o),
    .src_q  (src_data)
);

// File: tb/acc_rf_unit_test.sv
module acc_rf_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] op_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic dest_i = 1'b0, cy_i = 1'b0, hc_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [7:0] rd_data_o, acc_o;
    logic z_o, c_o;

    int total = 0;
    int bad = 0;

    logic [7:0] m_rf [DEPTH];
    logic [7:0] m_acc;
    logic       m_z, m_c;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_rf_unit #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .dest_i(dest_i),
        .cy_i(cy_i), .hc_i(hc_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .acc_o(acc_o), .z_o(z_o), .c_o(c_o)
    );

    // Decimal correction model (R7): returns {carry, value}
    function automatic logic [8:0] dadj_model(logic [7:0] a, logic cy, logic hc);
        logic lo, hi;
        logic [7:0] v;
        lo = (a[3:0] > 4'd9) || hc;
        hi = (a[7:4] > 4'd9) || cy;
        v  = a + (lo ? 8'h06 : 8'h00) + (hi ? 8'h60 : 8'h00);
        return {hi, v};
    endfunction

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h at %0t", req, got, exp, $time);
        end
    endtask

    // Model update for one operation
    task automatic model_step(logic [2:0] op, logic [AW-1:0] a, logic d, logic cy, logic hc);
        logic [7:0] inv;
        logic [8:0] r;
        inv = ~m_rf[a];
        case (op)
            3'd1: begin m_acc = 8'h00; m_z = 1'b1; end
            3'd2: begin m_rf[a] = 8'h00; m_z = 1'b1; end
            3'd3: begin
                m_z = (inv == 8'h00);
                if (d) m_rf[a] = inv; else m_acc = inv;
            end
            3'd4: begin r = dadj_model(m_acc, cy, hc); m_acc = r[7:0]; m_c = r[8]; end
            default: ;
        endcase
    endtask

    // Drive on falling edge, let one rising edge pass, check on next falling edge (R9)
    task automatic step(logic [2:0] op, logic [AW-1:0] a, logic d, logic cy, logic hc, string req);
        logic [AW-1:0] other;
        op_i = op; addr_i = a; dest_i = d; cy_i = cy; hc_i = hc;
        model_step(op, a, d, cy, hc);
        @(posedge clk);
        @(negedge clk);
        op_i = 3'd0;
        chk({req, " R9 acc"}, acc_o, m_acc);
        chk({req, " R9 z"}, {7'd0, z_o}, {7'd0, m_z});
        chk({req, " R9 c"}, {7'd0, c_o}, {7'd0, m_c});
        rd_addr_i = a;
        #1;
        chk({req, " R10 reg"}, rd_data_o, m_rf[a]);
        other = AW'($urandom);
        rd_addr_i = other;
        #1;
        chk({req, " R10 other reg"}, rd_data_o, m_rf[other]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL R9 watchdog expired got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) m_rf[i] = 8'h00;
        m_acc = 8'h00; m_z = 1'b0; m_c = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 acc", acc_o, 8'h00);
        chk("R1 z", {7'd0, z_o}, 8'h00);
        chk("R1 c", {7'd0, c_o}, 8'h00);
        for (int i = 0; i < DEPTH; i++) begin
            rd_addr_i = AW'(i);
            #1;
            chk("R1 reg", rd_data_o, 8'h00);
        end
        // Directed corners
        step(3'd2, 6'd5, 1'b0, 1'b0, 1'b0, "R3 clear reg");
        step(3'd3, 6'd5, 1'b0, 1'b0, 1'b0, "R4 inv to acc");   // acc FF, Z 0
        chk("R4 source kept", m_rf[5], 8'h00);
        step(3'd4, 6'd0, 1'b0, 1'b0, 1'b0, "R7 dadj FF");      // 65, C 1
        chk("R7 dadj FF value", acc_o, 8'h65);
        step(3'd5, 6'd5, 1'b1, 1'b1, 1'b1, "R8 code 5");
        step(3'd7, 6'd9, 1'b1, 1'b0, 1'b1, "R8 code 7");
        step(3'd1, 6'd0, 1'b0, 1'b0, 1'b0, "R2 clear acc");
        chk("R2 C kept", {7'd0, c_o}, 8'h01);
        step(3'd4, 6'd0, 1'b0, 1'b1, 1'b1, "R7 dadj 00 both"); // 66
        chk("R7 both value", acc_o, 8'h66);
        step(3'd3, 6'd9, 1'b1, 1'b0, 1'b0, "R5 inv to reg");   // reg9 FF, Z 0
        step(3'd3, 6'd9, 1'b1, 1'b0, 1'b0, "R6 inv zero");     // reg9 00, Z 1
        chk("R6 Z on zero", {7'd0, z_o}, 8'h01);
        step(3'd4, 6'd0, 1'b0, 1'b0, 1'b0, "R7 no fix");       // 66 stays, C 0
        chk("R7 no fix value", acc_o, 8'h66);
        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            logic [AW-1:0] a;
            int sel;
            sel = $urandom_range(0, 9);
            op = (sel < 3) ? 3'd4 : (sel < 6) ? 3'd3 : (sel == 6) ? 3'd1 :
                 (sel == 7) ? 3'd2 : 3'($urandom_range(0, 7));
            a = AW'($urandom_range(0, 7));
            step(op, a, 1'($urandom), 1'($urandom), 1'($urandom), "R2-R8 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule